// File: doc/BRIEF.md
# Radix-4 Signed-Digit Fractional Multiplier

This block multiplies two W-bit fractional two's complement operands in one registered stage. The multiplier operand is recoded into radix-4 signed digits, each taking one of the values 0, +1, +2, -2 or -1. This needs only about W/2 partial products instead of W. Each digit selects zero, the multiplicand or twice the multiplicand. A negative multiple is built as the one's complement of the positive multiple, plus a 1 injected at that row's least significant position. The rows are sign-extended to full width, shifted into place and summed.

The result is kept at the operand word length. Of the 2W-1 significant product bits, only the top W are returned, and the low W-1 bits are dropped. A strobe marks a new operand pair. The truncated product and its strobe appear on the next clock. An odd W is supported by widening the multiplier by one sign bit before it is recoded.

Top module: `r4m_mul`

## Requirements
- R1: With `in_vld` high, `prod` on the following cycle equals bits [2W-2:W-1] of the signed integer product opa×opb. This is the full-precision product shifted arithmetically right by W-1, keeping the low W bits.
- R2: `out_vld` is high in exactly the cycles that follow a cycle with `in_vld` high, so the latency is one clock.
- R3: When `in_vld` is low, `prod` keeps its previous value and `out_vld` is low, whatever the operand inputs carry.
- R4: While `rst_n` is low at a clock edge (synchronous, active low), `out_vld` and `prod` are cleared to zero.
- R5: A zero on either operand gives a zero product, including -1×0 and 0×(most positive value).
- R6: When the multiplier is the most negative code (value -1, bit pattern 1 followed by zeros), the result is the two's complement negation of opa modulo 2^W. In particular, -1×-1 wraps to the pattern 1 followed by zeros.
- R7: An odd W gives the same R1 result, with the multiplier sign-extended by one bit ahead of recoding.
- R8: Each multiplier triplet (b[2i+1], b[2i], b[2i-1]), with b[-1]=0, selects a row from this mapping: 000→0, 001→+A, 010→+A, 011→+2A, 100→-2A, 101→-A, 110→-A, 111→0. The selected row is shifted left by 2i.
- R9: The most positive operand squared returns the R1 value without overflow. That value is the most positive code less one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand pair present this cycle |
| opa | input | W | Multiplicand, fractional two's complement |
| opb | input | W | Multiplier, fractional two's complement |
| out_vld | output | 1 | Product valid, one cycle after in_vld |
| prod | output | W | Truncated product, top W bits of 2W-1 |

## Verification
The two functions that can fall in the same cycle are the load of a new product and the holding of the old one on a second, idle instance. The bench drives an even-width instance and an odd-width instance in lockstep through an exhaustive sweep. The odd-width instance receives operands only while both values fit its range and is idle for the rest of the sweep. In every cycle, the loaded instance is compared against the arithmetically shifted full product. The idle instance must show its last product unchanged and a low strobe. The sign corner cases, -1×-1, zero operands and max×max, are also applied as named steps.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

   typedef struct packed {
      logic zero;
      logic dbl;
      logic neg;
   } r4m_dig_t;

   function automatic r4m_dig_t r4m_decode(input logic [2:0] trip);
      r4m_dig_t d;
      d = '0;
      case (trip)
         3'b000: d.zero = 1'b1;
         3'b001: d = '0;
         3'b010: d = '0;
         3'b011: d.dbl = 1'b1;
         3'b100: begin d.dbl = 1'b1; d.neg = 1'b1; end
         3'b101: d.neg = 1'b1;
         3'b110: d.neg = 1'b1;
         default: d.zero = 1'b1;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/r4m_digit_enc.sv
module r4m_digit_enc
   import r4m_pkg::*;
#(
   parameter int ND = 4
) (
   input  logic [2*ND-1:0]         bext,
   output r4m_dig_t [ND-1:0]       dig
);
   localparam int PADW = 2*ND + 1;

   logic [PADW-1:0] bpad;

   // bit below the multiplier LSB is zero
   assign bpad = {bext, 1'b0};

   for (genvar i = 0; i < ND; i++) begin : g_dig
      assign dig[i] = r4m_decode(bpad[2*i+2 -: 3]);
   end

endmodule

// File: rtl/r4m_pp_gen.sv
module r4m_pp_gen
   import r4m_pkg::*;
#(
   parameter int W  = 8,
   parameter int PW = 16,
   parameter int SH = 0
) (
   input  logic [W-1:0]  mcand,
   input  r4m_dig_t      dig,
   output logic [PW-1:0] pp,
   output logic [PW-1:0] cin
);
   localparam int MW  = W + 1;
   localparam int EXT = PW - MW;

   logic [MW-1:0] one_x;
   logic [MW-1:0] two_x;
   logic [MW-1:0] sel;
   logic [MW-1:0] row;
   logic [PW-1:0] row_ext;

   initial begin
      if (EXT < 0) $error("r4m_pp_gen: PW too small");
      if (SH >= PW) $error("r4m_pp_gen: shift beyond row width");
   end

   assign one_x = {mcand[W-1], mcand};
   assign two_x = {mcand, 1'b0};

   always_comb begin
      if (dig.zero)     sel = '0;
      else if (dig.dbl) sel = two_x;
      else              sel = one_x;
   end

   assign row     = dig.neg ? ~sel : sel;
   assign row_ext = {{EXT{row[MW-1]}}, row};
   assign pp      = row_ext << SH;
   assign cin     = {{(PW-1){1'b0}}, dig.neg} << SH;

endmodule

// File: rtl/r4m_accum.sv
module r4m_accum #(
   parameter int PW = 16,
   parameter int N  = 4
) (
   input  logic [N-1:0][PW-1:0] rows,
   input  logic [N-1:0][PW-1:0] cins,
   output logic [PW-1:0]        sum
);
   logic [PW-1:0] corr;
   logic [PW-1:0] acc;

   // injected ones sit on distinct even positions, so they merge by OR
   always_comb begin
      corr = '0;
      for (int i = 0; i < N; i++) corr = corr | cins[i];
   end

   always_comb begin
      acc = corr;
      for (int i = 0; i < N; i++) acc = acc + rows[i];
   end

   assign sum = acc;

endmodule

// File: rtl/r4m_mul.sv
module r4m_mul
   import r4m_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic         out_vld,
   output logic [W-1:0] prod
);
   localparam int ND = (W + 1) / 2;
   localparam int BW = 2 * ND;
   localparam int PW = 2 * W;
   localparam int HI = 2 * W - 2;

   logic [BW-1:0]         bext;
   r4m_dig_t [ND-1:0]     dig;
   logic [ND-1:0][PW-1:0] rows;
   logic [ND-1:0][PW-1:0] cins;
   logic [PW-1:0]         sum;
   logic [W-1:0]          trunc;

   if (W < 2) begin : g_bad_w
      initial $error("r4m_mul: W must be at least 2");
   end

   // odd widths need one extra sign bit to fill the last triplet
   if (W % 2 == 1) begin : g_odd
      assign bext = {opb[W-1], opb};
   end else begin : g_even
      assign bext = opb;
   end

   r4m_digit_enc #(.ND(ND)) i_enc (
      .bext (bext),
      .dig  (dig)
   );

   for (genvar i = 0; i < ND; i++) begin : g_row
      r4m_pp_gen #(.W(W), .PW(PW), .SH(2*i)) i_pp (
         .mcand (opa),
         .dig   (dig[i]),
         .pp    (rows[i]),
         .cin   (cins[i])
      );
   end

   r4m_accum #(.PW(PW), .N(ND)) i_acc (
      .rows (rows),
      .cins (cins),
      .sum  (sum)
   );

   assign trunc = sum[HI -: W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         prod    <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) prod <= trunc;
      end
   end

endmodule

// File: rtl/r4m_mul_chk.sv
module r4m_mul_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_vld,
   input logic [W-1:0] opa,
   input logic [W-1:0] opb,
   input logic         out_vld,
   input logic [W-1:0] prod
);
   localparam int PW = 2 * W;
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic [PW-1:0] full;
   logic [W-1:0]  ref_q;
   logic [W-1:0]  neg_a;

   assign full  = {{W{opa[W-1]}}, opa} * {{W{opb[W-1]}}, opb};
   assign ref_q = full[2*W-2 -: W];
   assign neg_a = '0 - opa;

   // R1
   product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> prod == $past(ref_q));

   // R2
   strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R2
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   // R3
   hold_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(prod));

   // R5
   zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (opa == '0 || opb == '0)) |=> prod == '0);

   // R6
   neg_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && opb == MINV) |=> prod == $past(neg_a));

endmodule

bind r4m_mul r4m_mul_chk #(.W(W)) i_r4m_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .opa     (opa),
   .opb     (opb),
   .out_vld (out_vld),
   .prod    (prod)
);

// File: tb/test_r4m_mul.sv
module test_r4m_mul;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       v6, v5;
   logic [5:0] a6, b6, p6;
   logic [4:0] a5, b5, p5;
   logic       o6, o5;
   int         n_chk = 0;
   int         n_bad = 0;
   logic [4:0] last5;

   always #(CLK_PERIOD/2) clk = ~clk;

   r4m_mul #(.W(6)) i_r4m_mul (
      .clk(clk), .rst_n(rst_n), .in_vld(v6), .opa(a6), .opb(b6),
      .out_vld(o6), .prod(p6)
   );

   r4m_mul #(.W(5)) i_r4m_mul_odd (
      .clk(clk), .rst_n(rst_n), .in_vld(v5), .opa(a5), .opb(b5),
      .out_vld(o5), .prod(p5)
   );

   function automatic logic [31:0] ref_prod(int a, int b, int w);
      longint sa, sb, p;
      sa = (a >= (1 << (w-1))) ? longint'(a) - (longint'(1) << w) : longint'(a);
      sb = (b >= (1 << (w-1))) ? longint'(b) - (longint'(1) << w) : longint'(b);
      p  = (sa * sb) >>> (w-1);
      return 32'(p & ((longint'(1) << w) - 1));
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step6(int a, int b);
      a6 = 6'(a); b6 = 6'(b); v6 = 1'b1; v5 = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; v6 = 1'b0; v5 = 1'b0;
      a6 = '1; b6 = '1; a5 = '1; b5 = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R4: reset clears both instances
      chk("R4 vld6", 32'(o6), 0);
      chk("R4 prod6", 32'(p6), 0);
      chk("R4 vld5", 32'(o5), 0);
      chk("R4 prod5", 32'(p5), 0);
      rst_n = 1'b1;
      last5 = '0;

      // R1/R7 sweep; R2/R3 on the odd instance when it idles
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            a6 = 6'(a); b6 = 6'(b); v6 = 1'b1;
            a5 = 5'(b); b5 = 5'(a);
            v5 = (a < 32 && b < 32);
            @(posedge clk); @(negedge clk);
            chk("R1", 32'(p6), ref_prod(a, b, 6));
            chk("R2", 32'(o6), 1);
            if (a < 32 && b < 32) begin
               chk("R7", 32'(p5), ref_prod(b, a, 5));
               chk("R2 odd", 32'(o5), 1);
               last5 = p5;
            end else begin
               chk("R3 hold", 32'(p5), 32'(last5));
               chk("R2 idle", 32'(o5), 0);
            end
         end
      end

      // R3: idle cycle with changed operands
      step6(7, 9);
      a6 = 6'd31; b6 = 6'd31; v6 = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R3 prod", 32'(p6), ref_prod(7, 9, 6));
      chk("R3 vld", 32'(o6), 0);

      // R5: zero operands
      step6(32, 0);
      chk("R5 -1x0", 32'(p6), 0);
      step6(0, 31);
      chk("R5 0xmax", 32'(p6), 0);

      // R6: multiplier -1
      step6(32, 32);
      chk("R6 -1x-1", 32'(p6), 32'h20);
      step6(5, 32);
      chk("R6 5x-1", 32'(p6), 32'h3b);

      // R9: max squared
      step6(31, 31);
      chk("R9", 32'(p6), ref_prod(31, 31, 6));
      chk("R9 value", 32'(p6), 32'h1e);

      // R8: every triplet at digit 1 (bits 3..1), bit 0 clear
      for (int t = 0; t < 8; t++) begin
         step6(13, t << 1);
         chk("R8", 32'(p6), ref_prod(13, t << 1, 6));
      end

      v6 = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule